// File: doc/BRIEF.md
# Interlocked Handshake Bus Initiator

This block is the initiating side of a clockless, fully interlocked request/acknowledge bus with separate address and data lines. A user-side command selects a single read, a single write or an atomic read-modify-write. The block then steps through the handshake. It presents the address and a transfer-kind code first. It waits a programmable number of clock cycles for those lines to settle and only then raises a read or write strobe. After that, each step waits for the opposite level of the responder's acknowledge before going on.

The acknowledge input is brought into the clock domain through a short flop chain before any decision uses it. For a read-modify-write, the address goes out once and stays unchanged through a read and the write that follows it. The write carries the read value transformed by a selectable function with an operand. A lock output keeps other initiators away from the location for the whole sequence. If the responder stalls, a watchdog ends the transfer, releases the bus and reports an error.

Top module: `hs_bus_master`

## Requirements
- R1: While reset is high and in the first idle cycle after it, busy, done, err, bus_rd, bus_wr and bus_lock are low, and bus_addr and bus_ctl are zero.
- R2: A command is taken only when the block is idle, the synchronized acknowledge is low and cmd_kind is 0 (read), 1 (write) or 2 (read-modify-write). Code 3 is never taken. Busy is high from the cycle after acceptance until the cycle that carries done or err. Commands offered while busy are dropped.
- R3: For a read, bus_addr and bus_ctl = 01 appear together, and bus_rd rises exactly SETTLE_CYC clock cycles after them.
- R4: rd_data takes bus_rdata as sampled while the synchronized acknowledge is high, and bus_rd then falls. bus_addr and bus_ctl stay unchanged while acknowledge is high. Only after acknowledge is seen low does done pulse, and bus_addr and bus_ctl return to zero.
- R5: For a write, bus_wdata is presented in the same cycle as bus_addr and bus_ctl = 10. bus_wr rises SETTLE_CYC cycles later, and bus_wdata stays stable while bus_wr is high.
- R6: A write ends with bus_wr falling after acknowledge is seen high. Done pulses only after acknowledge is seen low again.
- R7: A read-modify-write shows bus_ctl = 11. It issues one address that holds through exactly one read strobe and then exactly one write strobe to the same address.
- R8: The read-modify-write function is chosen by cmd_op, with cmd_wdata as the operand: 0 is the sum modulo 2^DW, 1 is bitwise OR, 2 is AND with the inverted operand, and 3 is a plain replacement by the operand. rd_data returns the value as read, before modification.
- R9: bus_lock is high from the cycle after a read-modify-write is accepted until acknowledge has been seen low after its write. It stays low during plain reads and writes.
- R10: If acknowledge does not reach the awaited level within TIMEOUT_CYC cycles, the block pulses err without done, drops both strobes and the lock, and returns to idle.
- R11: bus_rd and bus_wr are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_kind | input | 2 | 0 read, 1 write, 2 read-modify-write |
| cmd_addr | input | AW | Target address |
| cmd_wdata | input | DW | Write data, or operand for read-modify-write |
| cmd_op | input | 2 | Modify function select |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle timeout pulse |
| rd_data | output | DW | Last value read from the bus |
| bus_addr | output | AW | Address lines |
| bus_ctl | output | 2 | Transfer kind: 01 read, 10 write, 11 RMW, 00 idle |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | DW | Data lines toward the responder |
| bus_lock | output | 1 | Atomic sequence lock |
| bus_ack | input | 1 | Responder acknowledge (asynchronous) |
| bus_rdata | input | DW | Data lines from the responder |

## Verification
The bench builds the block with AW = 8, DW = 16, SETTLE_CYC = 3 and TIMEOUT_CYC = 40. With a short settle count, the exact strobe placement can be counted cycle by cycle against the address phase. With a 40-cycle timeout, a stalled responder reaches the abort path quickly, while responder delays of zero to three cycles stay well inside the limit. The 16-bit data width lets the sum wrap past the top of the range, and each of the four modify functions can be checked with patterns that tell them apart.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    CMD_READ  = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_RMW   = 2'd2,
    CMD_NONE  = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_OR   = 2'd1,
    OP_ANDN = 2'd2,
    OP_SET  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RSET,
    S_RHI,
    S_RLO,
    S_WSET,
    S_WHI,
    S_WLO
  } st_e;

  localparam logic [1:0] CTL_IDLE = 2'b00;
  localparam logic [1:0] CTL_RD   = 2'b01;
  localparam logic [1:0] CTL_WR   = 2'b10;
  localparam logic [1:0] CTL_RMW  = 2'b11;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_timer.sv
module hs_timer #(
  parameter int W      = 8,
  parameter int SETTLE = 4,
  parameter int LIMIT  = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic settle_hit,
  output logic tmo_hit
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)      cnt <= '0;
    else if (cnt != '1)  cnt <= cnt + 1'b1;
  end

  assign settle_hit = (cnt == W'(SETTLE - 1));
  assign tmo_hit    = (cnt == W'(LIMIT - 1));
endmodule

// File: rtl/hs_modify.sv
module hs_modify
  import hs_pkg::*;
#(
  parameter int DW = 32
) (
  input  op_e           op,
  input  logic [DW-1:0] cur,
  input  logic [DW-1:0] opnd,
  output logic [DW-1:0] res
);
  always_comb begin
    case (op)
      OP_ADD:  res = cur + opnd;
      OP_OR:   res = cur | opnd;
      OP_ANDN: res = cur & ~opnd;
      default: res = opnd;
    endcase
  end
endmodule

// File: rtl/hs_bus_master.sv
module hs_bus_master
  import hs_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DW          = 32,
  parameter int SETTLE_CYC  = 4,
  parameter int TIMEOUT_CYC = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_kind,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic [1:0]    cmd_op,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_ctl,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_lock,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata
);
  localparam int MAXC = (TIMEOUT_CYC > SETTLE_CYC) ? TIMEOUT_CYC : SETTLE_CYC;
  localparam int TW   = $clog2(MAXC + 1) + 1;

  st_e           st_q, st_d;
  cmd_e          kind_q;
  op_e           op_q;
  logic [DW-1:0] opnd_q;
  logic [DW-1:0] mod_res;
  logic          ack_s, settle_hit, tmo_hit, tmr_clr;
  logic          accept, fin, abt;

  hs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(bus_ack), .q(ack_s)
  );

  hs_timer #(.W(TW), .SETTLE(SETTLE_CYC), .LIMIT(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst(rst), .clr(tmr_clr),
    .settle_hit(settle_hit), .tmo_hit(tmo_hit)
  );

  hs_modify #(.DW(DW)) u_mod (
    .op(op_q), .cur(rd_data), .opnd(opnd_q), .res(mod_res)
  );

  assign accept = (st_q == S_IDLE) && cmd_valid && !ack_s && (cmd_kind != CMD_NONE);

  always_comb begin
    st_d = st_q;
    fin  = 1'b0;
    abt  = 1'b0;
    case (st_q)
      S_IDLE: if (accept) st_d = (cmd_kind == CMD_WRITE) ? S_WSET : S_RSET;
      S_RSET: if (settle_hit) st_d = S_RHI;
      S_RHI: begin
        if (ack_s)        st_d = S_RLO;
        else if (tmo_hit) begin st_d = S_IDLE; abt = 1'b1; end
      end
      S_RLO: begin
        if (!ack_s) begin
          if (kind_q == CMD_RMW) st_d = S_WSET;
          else begin st_d = S_IDLE; fin = 1'b1; end
        end else if (tmo_hit) begin st_d = S_IDLE; abt = 1'b1; end
      end
      S_WSET: if (settle_hit) st_d = S_WHI;
      S_WHI: begin
        if (ack_s)        st_d = S_WLO;
        else if (tmo_hit) begin st_d = S_IDLE; abt = 1'b1; end
      end
      S_WLO: begin
        if (!ack_s)       begin st_d = S_IDLE; fin = 1'b1; end
        else if (tmo_hit) begin st_d = S_IDLE; abt = 1'b1; end
      end
      default: st_d = S_IDLE;
    endcase
  end

  assign tmr_clr = (st_d != st_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      kind_q    <= CMD_READ;
      op_q      <= OP_ADD;
      opnd_q    <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      rd_data   <= '0;
      bus_addr  <= '0;
      bus_ctl   <= CTL_IDLE;
      bus_rd    <= 1'b0;
      bus_wr    <= 1'b0;
      bus_wdata <= '0;
      bus_lock  <= 1'b0;
    end else begin
      st_q <= st_d;
      done <= fin;
      err  <= abt;
      case (st_q)
        S_IDLE: if (accept) begin
          kind_q   <= cmd_e'(cmd_kind);
          op_q     <= op_e'(cmd_op);
          opnd_q   <= cmd_wdata;
          bus_addr <= cmd_addr;
          bus_lock <= (cmd_kind == CMD_RMW);
          case (cmd_kind)
            CMD_WRITE: begin bus_ctl <= CTL_WR; bus_wdata <= cmd_wdata; end
            CMD_RMW:   bus_ctl <= CTL_RMW;
            default:   bus_ctl <= CTL_RD;
          endcase
        end
        S_RSET: if (settle_hit) bus_rd <= 1'b1;
        S_RHI: if (ack_s) begin
          rd_data <= bus_rdata;
          bus_rd  <= 1'b0;
        end
        S_RLO: if (!ack_s && kind_q == CMD_RMW) bus_wdata <= mod_res;
        S_WSET: if (settle_hit) bus_wr <= 1'b1;
        S_WHI: if (ack_s) bus_wr <= 1'b0;
        default: ;
      endcase
      if (fin || abt) begin
        bus_rd    <= 1'b0;
        bus_wr    <= 1'b0;
        bus_lock  <= 1'b0;
        bus_addr  <= '0;
        bus_ctl   <= CTL_IDLE;
        bus_wdata <= '0;
      end
    end
  end

  assign busy = (st_q != S_IDLE);

  // Assertions
  p_excl_strobe_r11: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));

  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cmd_valid && !ack_s));

  p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(bus_addr) && $stable(bus_ctl)));

  p_wdata_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && $past(bus_wr)) |-> $stable(bus_wdata));

  p_lock_rmw_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && kind_q == CMD_RMW) |-> bus_lock);

  p_lock_plain_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && kind_q != CMD_RMW) |-> !bus_lock);

  p_done_err_r10: assert property (@(posedge clk) disable iff (rst)
    !(done && err));

  p_abort_release_r10: assert property (@(posedge clk) disable iff (rst)
    err |-> (!bus_rd && !bus_wr && !bus_lock && !busy));
endmodule

// File: tb/hs_bus_master_test.sv
module hs_bus_master_test;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int SETTLE = 3;
  localparam int TMO = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_kind = 2'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic [1:0] cmd_op = 2'd0;
  logic busy, done, err;
  logic [DW-1:0] rd_data, bus_wdata;
  logic [AW-1:0] bus_addr;
  logic [1:0] bus_ctl;
  logic bus_rd, bus_wr, bus_lock;
  logic bus_ack = 1'b0;
  logic [DW-1:0] bus_rdata = '0;

  hs_bus_master #(.AW(AW), .DW(DW), .SETTLE_CYC(SETTLE), .TIMEOUT_CYC(TMO)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_op(cmd_op),
    .busy(busy), .done(done), .err(err), .rd_data(rd_data),
    .bus_addr(bus_addr), .bus_ctl(bus_ctl), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_lock(bus_lock), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // responder
  logic [DW-1:0] mem [16];
  int dly = 2, dc = 0;
  bit stuck = 0, hold_hi = 0;
  initial begin
    for (int i = 0; i < 16; i++) mem[i] = DW'(16'h1000 + i * 16'h0111);
    forever begin
      @(negedge clk);
      if (hold_hi) bus_ack = 1'b1;
      else if (stuck) ;
      else if (bus_rd && !bus_ack) begin
        if (dc == dly) begin bus_rdata = mem[bus_addr[3:0]]; dc++; end
        else if (dc > dly) bus_ack = 1'b1;
        else dc++;
      end else if (bus_wr && !bus_ack) begin
        if (dc >= dly) begin mem[bus_addr[3:0]] = bus_wdata; bus_ack = 1'b1; end
        else dc++;
      end else if (!bus_rd && !bus_wr && bus_ack) begin
        bus_ack = 1'b0; bus_rdata = '0; dc = 0;
      end
    end
  end

  // bus monitor
  int t_ctl, t_rd, t_wr, rd_rises = 0, wr_rises = 0, busy_rises = 0;
  int addr_viol = 0, ack_viol = 0, both_hi = 0, lock_cyc = 0, lock_drop = 0;
  bit lock_expect = 0;
  logic [1:0] ctl_at_start;
  logic [DW-1:0] wd_at_start, wd_at_wr;
  logic [AW-1:0] addr_at_wr, p_addr;
  logic p_ctl_nz = 0, p_rd = 0, p_wr = 0, p_busy = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (bus_ctl != 2'b00 && !p_ctl_nz) begin t_ctl = cyc; ctl_at_start = bus_ctl; wd_at_start = bus_wdata; end
      if (bus_rd && !p_rd) begin t_rd = cyc; rd_rises++; end
      if (bus_wr && !p_wr) begin t_wr = cyc; wr_rises++; wd_at_wr = bus_wdata; addr_at_wr = bus_addr; end
      if (busy && !p_busy) busy_rises++;
      if (busy && p_busy && bus_addr != p_addr) addr_viol++;
      if (bus_ack && bus_ctl == 2'b00 && !hold_hi && !stuck) ack_viol++;
      if (bus_rd && bus_wr) both_hi++;
      if (bus_lock) lock_cyc++;
      if (lock_expect && busy && !bus_lock) lock_drop++;
    end
    p_ctl_nz = (bus_ctl != 2'b00); p_rd = bus_rd; p_wr = bus_wr;
    p_busy = busy; p_addr = bus_addr;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  bit got_done, got_err;
  task automatic wait_end();
    got_done = 0; got_err = 0;
    for (int i = 0; i < 400 && !got_done && !got_err; i++) begin
      @(negedge clk);
      if (done) got_done = 1;
      if (err)  got_err = 1;
    end
  endtask

  task automatic issue(input logic [1:0] k, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] op);
    @(negedge clk);
    cmd_kind = k; cmd_addr = a; cmd_wdata = d; cmd_op = op; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic t_reset();
    check(!busy && !done && !err, "R1 status", {busy, done, err}, 0);
    check(!bus_rd && !bus_wr && !bus_lock, "R1 strobes", {bus_rd, bus_wr, bus_lock}, 0);
    check(bus_addr == 0 && bus_ctl == 0, "R1 address", {bus_addr, bus_ctl}, 0);
  endtask

  task automatic t_read(input logic [AW-1:0] a, input int d);
    logic [DW-1:0] exp = mem[a[3:0]];
    int av = addr_viol, kv = ack_viol;
    dly = d;
    issue(2'd0, a, '0, 2'd0);
    wait_end();
    check(got_done && !got_err, "R4 done", {got_done, got_err}, 2'b10);
    check(ctl_at_start == 2'b01, "R3 ctl", ctl_at_start, 2'b01);
    check(t_rd - t_ctl == SETTLE, "R3 settle", t_rd - t_ctl, SETTLE);
    check(rd_data == exp, "R4 data", rd_data, exp);
    check(addr_viol == av && ack_viol == kv, "R4 hold", addr_viol + ack_viol, av + kv);
    check(bus_addr == 0 && bus_ctl == 0 && !busy, "R4 release", {bus_addr, bus_ctl}, 0);
  endtask

  task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] v, input int d);
    int lc = lock_cyc;
    dly = d;
    issue(2'd1, a, v, 2'd0);
    wait_end();
    check(got_done, "R6 done", got_done, 1);
    check(mem[a[3:0]] == v, "R6 stored", mem[a[3:0]], v);
    check(ctl_at_start == 2'b10 && wd_at_start == v, "R5 early data", wd_at_start, v);
    check(t_wr - t_ctl == SETTLE, "R5 settle", t_wr - t_ctl, SETTLE);
    check(!bus_wr && !bus_ack, "R6 closed", {bus_wr, bus_ack}, 0);
    check(lock_cyc == lc, "R9 no lock on write", lock_cyc - lc, 0);
  endtask

  task automatic t_rmw(input logic [AW-1:0] a, input logic [1:0] op, input logic [DW-1:0] opnd);
    logic [DW-1:0] old = mem[a[3:0]], exp;
    int rr = rd_rises, wr = wr_rises, av = addr_viol, lc = lock_cyc;
    case (op)
      2'd0: exp = old + opnd;
      2'd1: exp = old | opnd;
      2'd2: exp = old & ~opnd;
      default: exp = opnd;
    endcase
    lock_drop = 0; lock_expect = 1;
    issue(2'd2, a, opnd, op);
    wait_end();
    lock_expect = 0;
    check(got_done && ctl_at_start == 2'b11, "R7 done/ctl", ctl_at_start, 2'b11);
    check(rd_rises - rr == 1 && wr_rises - wr == 1, "R7 one read one write",
          {rd_rises - rr, wr_rises - wr}, {32'd1, 32'd1});
    check(addr_viol == av && addr_at_wr == a, "R7 same address", addr_at_wr, a);
    check(rd_data == old, "R8 old value", rd_data, old);
    check(mem[a[3:0]] == exp, "R8 modified value", mem[a[3:0]], exp);
    check(lock_drop == 0 && lock_cyc > lc && !bus_lock, "R9 lock span", lock_drop, 0);
  endtask

  task automatic t_accept();
    int br = busy_rises, wr = wr_rises;
    hold_hi = 1;
    repeat (4) @(negedge clk);
    @(negedge clk);
    cmd_kind = 2'd0; cmd_addr = 8'h03; cmd_valid = 1'b1;
    repeat (10) @(negedge clk);
    cmd_valid = 1'b0;
    check(busy_rises == br, "R2 ack high blocks", busy_rises - br, 0);
    hold_hi = 0;
    repeat (6) @(negedge clk);
    issue(2'd3, 8'h03, '0, 2'd0);
    repeat (4) @(negedge clk);
    check(busy_rises == br, "R2 code 3 refused", busy_rises - br, 0);
    dly = 2;
    issue(2'd0, 8'h04, '0, 2'd0);
    issue(2'd1, 8'h05, 16'hdead, 2'd0);
    wait_end();
    repeat (8) @(negedge clk);
    check(busy_rises - br == 1 && wr_rises == wr, "R2 busy drops cmd", busy_rises - br, 1);
  endtask

  task automatic t_timeout();
    int dn;
    stuck = 1;
    issue(2'd2, 8'h06, 16'h0001, 2'd0);
    wait_end();
    dn = got_done;
    check(got_err && !dn, "R10 err not done", {got_err, dn}, 2'b10);
    check(!bus_rd && !bus_wr && !bus_lock && !busy, "R10 released",
          {bus_rd, bus_wr, bus_lock, busy}, 0);
    stuck = 0;
    repeat (4) @(negedge clk);
    t_read(8'h06, 1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read(8'h02, 0);
    t_read(8'h0b, 3);
    t_write(8'h07, 16'h5a5a, 1);
    t_write(8'h08, 16'h00ff, 3);
    t_read(8'h07, 2);
    t_rmw(8'h09, 2'd0, 16'hf000);
    t_rmw(8'h0a, 2'd1, 16'h0f0f);
    t_rmw(8'h0c, 2'd2, 16'h1111);
    t_rmw(8'h0d, 2'd3, 16'hbeef);
    t_accept();
    t_timeout();
    check(both_hi == 0, "R11 exclusive strobes", both_hi, 0);
    finish_run();
  end
endmodule